// File: doc/BRIEF.md
# Clocked Addressable Bit Register with Decode Mode

This block holds a small array of single-bit cells, one of which is chosen at a time by a binary index. Two active-low control inputs, a write enable and a group clear, pick one of four operating modes on every rising clock edge. The modes are: write one bit, hold every bit, decode the input bit onto one line, and clear every bit. Each cell drives its own output line, so a stream of serial bits can be spread out into a parallel word, one index at a time.

In decode mode the chosen cell is loaded with the data bit and every other cell is forced to zero. With the data input held high, this turns the block into an active-high one-of-N decoder. All actions are synchronous and the outputs come straight from the register. A separate active-high synchronous reset clears the array; it is independent of the group clear. The index should be changed only while the block holds, because an index that changes during a write could pick the wrong cell.

Top module: `addr_bit_reg`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs are 0 after that edge.
- R2: Write mode (`wr_n`=0, `clr_n`=1): at the edge, output bit `sel` (bit i of `q_out` is cell i) takes `din`, and every other bit keeps its value.
- R3: Hold mode (`wr_n`=1, `clr_n`=1): at the edge, all outputs keep their value, whatever `din` and `sel` are.
- R4: Decode mode (`wr_n`=0, `clr_n`=0): after the edge, bit `sel` equals `din` and all other bits are 0, so at most one bit is set.
- R5: Clear mode (`wr_n`=1, `clr_n`=0): after the edge, all outputs are 0, whatever `din` and `sel` are.
- R6: A hold that follows decode mode keeps exactly the pattern that decode mode left.
- R7: With `din`=1, decode mode gives the one-hot value 1<<`sel` for every index 0 to 7.
- R8: Bits written one index at a time in write mode build up a full parallel word that stays in place through later holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all actions happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears every cell |
| din | input | 1 | Data bit |
| sel | input | 3 | Index of the chosen cell |
| wr_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low group clear |
| q_out | output | 8 | Cell contents; bit i is cell i |

## Verification
Every result is due one clock edge after the inputs that cause it, because the outputs come straight from the register. The bench drives its inputs on the falling edge. It advances a behavioural reference model at each rising edge and compares `q_out` with it half a period later, so each comparison sees exactly one update. Directed sequences cover each mode at every index, decode followed by hold, clear followed by hold, and a serial-to-parallel fill. A random phase then mixes all the modes.

// File: rtl/addr_bit_reg_pkg.sv
package addr_bit_reg_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'b00,
        MODE_HOLD   = 2'b01,
        MODE_DECODE = 2'b10,
        MODE_CLEAR  = 2'b11
    } op_mode_e;

    // Map the active-low controls onto an operating mode.
    function automatic op_mode_e pick_mode(input logic wr_n, input logic clr_n);
        if (clr_n) return wr_n ? MODE_HOLD  : MODE_WRITE;
        else       return wr_n ? MODE_CLEAR : MODE_DECODE;
    endfunction
endpackage

// File: rtl/abr_index_decode.sv
module abr_index_decode #(
    parameter int CELLS = 8,
    localparam int IW = $clog2(CELLS)
) (
    input  logic [IW-1:0]    idx,
    output logic [CELLS-1:0] hit
);
    for (genvar g = 0; g < CELLS; g++) begin : g_dec
        assign hit[g] = (idx == IW'(g));
    end
endmodule

// File: rtl/abr_cell_update.sv
module abr_cell_update #(
    parameter int CELLS = 8
) (
    input  addr_bit_reg_pkg::op_mode_e mode,
    input  logic [CELLS-1:0]           hit,
    input  logic                       bit_in,
    input  logic [CELLS-1:0]           cur,
    output logic [CELLS-1:0]           nxt
);
    import addr_bit_reg_pkg::*;
    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        always_comb begin
            unique case (mode)
                MODE_WRITE:  nxt[g] = hit[g] ? bit_in : cur[g];
                MODE_HOLD:   nxt[g] = cur[g];
                MODE_DECODE: nxt[g] = hit[g] & bit_in;
                default:     nxt[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/addr_bit_reg.sv
module addr_bit_reg #(
    parameter int CELLS = 8,
    localparam int IW = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [IW-1:0]    sel,
    input  logic             wr_n,
    input  logic             clr_n,
    output logic [CELLS-1:0] q_out
);
    import addr_bit_reg_pkg::*;

    typedef struct packed {
        logic [CELLS-1:0] cells;
    } state_t;

    state_t state_d, state_q;
    op_mode_e mode;
    logic [CELLS-1:0] hit;
    logic [CELLS-1:0] upd;

    abr_index_decode #(.CELLS(CELLS)) dec_i (.idx(sel), .hit(hit));

    abr_cell_update #(.CELLS(CELLS)) upd_i (
        .mode(mode), .hit(hit), .bit_in(din), .cur(state_q.cells), .nxt(upd)
    );

    always_comb begin
        mode = pick_mode(wr_n, clr_n);
        state_d = state_q;
        state_d.cells = upd;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign q_out = state_q.cells;
endmodule

// File: rtl/addr_bit_reg_chk.sv
module addr_bit_reg_chk #(
    parameter int CELLS = 8,
    localparam int IW = $clog2(CELLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic [IW-1:0]    sel,
    input logic             wr_n,
    input logic             clr_n,
    input logic [CELLS-1:0] q_out
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q_out == '0));

    assert_write_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && clr_n) |=> (q_out[$past(sel)] == $past(din)));

    assert_write_others_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && clr_n) |=> ((q_out & ~(CELLS'(1) << $past(sel))) ==
                              ($past(q_out) & ~(CELLS'(1) << $past(sel)))));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_n && clr_n) |=> $stable(q_out));

    assert_decode_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !clr_n) |=> ($onehot0(q_out) && q_out[$past(sel)] == $past(din)));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_n && !clr_n) |=> (q_out == '0));
endmodule

bind addr_bit_reg addr_bit_reg_chk #(.CELLS(CELLS)) chk_i (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .wr_n(wr_n), .clr_n(clr_n), .q_out(q_out)
);

// File: tb/addr_bit_reg_tb.sv
`timescale 1ns/1ps
module addr_bit_reg_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [2:0] sel = '0;
    logic wr_n = 1'b1;
    logic clr_n = 1'b1;
    logic [7:0] q_out;

    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] model = '0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    addr_bit_reg dut_i (.*);

    // Reference model: advances at every rising edge.
    always @(posedge clk) begin
        if (rst) model <= '0;
        else begin
            case ({wr_n, clr_n})
                2'b01: begin
                    model <= model;
                    model[sel] <= din;
                end
                2'b11: model <= model;
                2'b00: model <= 8'(din) << sel;
                default: model <= '0;
            endcase
        end
    end

    // Compare half a period after each edge.
    always @(negedge clk) begin
        n_tests++;
        if (q_out !== model) begin
            n_fail++;
            $display("FAIL %s: q_out=%b expected=%b", tag, q_out, model);
        end
    end

    task automatic step(input logic w, input logic c, input logic d, input int s);
        @(negedge clk);
        wr_n = w;
        clr_n = c;
        din = d;
        sel = 3'(s);
    endtask

    task automatic expect_val(input string r, input logic [7:0] e);
        @(negedge clk);
        n_tests++;
        if (q_out !== e) begin
            n_fail++;
            $display("FAIL %s: q_out=%b expected=%b", r, q_out, e);
        end
    endtask

    initial begin
        fork
            begin
                #(5.0 * 200000);
                n_fail++;
                $display("FAIL watchdog: q_out=%b expected=done", q_out);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_val("R1", 8'h00);

        // R8: serial fill via write mode, pattern 10110010
        tag = "R8";
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, logic'((8'hB2 >> i) & 1), i);
        step(1'b1, 1'b1, 1'b1, 5);
        expect_val("R8", 8'hB2);
        // R3: hold ignores din and sel
        tag = "R3";
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, logic'(i & 1), 7 - i);
        expect_val("R3", 8'hB2);
        // R2: overwrite single bits
        tag = "R2";
        step(1'b0, 1'b1, 1'b0, 1);
        step(1'b0, 1'b1, 1'b1, 0);
        step(1'b1, 1'b1, 1'b0, 0);
        expect_val("R2", 8'hB1);
        // R7/R4/R6: decode each index, then hold
        for (int i = 0; i < 8; i++) begin
            tag = "R7";
            step(1'b0, 1'b0, 1'b1, i);
            step(1'b1, 1'b1, 1'b0, 7 - i);
            expect_val("R7", 8'(1) << i);
            tag = "R6";
            step(1'b1, 1'b1, 1'b1, i);
            expect_val("R6", 8'(1) << i);
        end
        tag = "R4";
        step(1'b0, 1'b0, 1'b0, 3);
        step(1'b1, 1'b1, 1'b1, 3);
        expect_val("R4", 8'h00);
        // R5: clear from a full word, then hold
        tag = "R5";
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, i);
        step(1'b1, 1'b0, 1'b1, 6);
        step(1'b1, 1'b1, 1'b1, 6);
        expect_val("R5", 8'h00);
        // Mixed random phase
        tag = "R2 R3 R4 R5";
        for (int i = 0; i < 2000; i++)
            step(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 3) != 0),
                 logic'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
        tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        expect_val("R1", 8'h00);
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule